// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block services address-translation misses. When a miss is handed over, it walks a four-level radix page table in memory and reads one 64-bit entry per level, top level first. It picks a 9-bit slice of the virtual address as the index at each level and uses the frame found in the previous entry as the next table base. The first table base comes from the root base input. A page-size flag in the entry from the second or third read ends the walk early with a 1 GB or 2 MB mapping. Otherwise the walk reads all four levels and resolves a 4 KB page.

A completed walk produces a one-cycle fill for the translation buffer. The fill carries the virtual page number, the physical page number, a page-size code and the requester's tag. A non-present entry at any level stops the walk and produces a one-cycle fault that carries the level and the tag. Free-running counters record completions for each page size, faults, and the number of cycles a walk was in progress.

The controller has five states. IDLE waits for a miss. REQ holds a memory read until it is granted. WAIT waits for the read data. FILL and FAULT each present a result for one cycle. The transitions are:
- IDLE to REQ on a miss.
- REQ to WAIT on grant.
- WAIT to REQ for a non-leaf present entry.
- WAIT to FILL for a leaf.
- WAIT to FAULT for a non-present entry.
- FILL and FAULT back to IDLE.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle. Busy, memory request, fill and fault are low, and all five counters read zero.
- R2: A miss is accepted only in the idle state. Busy is high from the cycle after acceptance through the fill or fault cycle, and low in the cycle after that. A miss presented while busy is ignored and starts no walk.
- R3: For read number n (1 to 4), the read address is {table frame, index, 3'b000}. The index is va[47:39], va[38:30], va[29:21] or va[20:12] in that order. The table frame for read 1 is root_base[51:12]. For each later read it is bits [51:12] of the previous entry.
- R4: Only one read is outstanding at a time. A request holds its address steady until mem_req_ready, and no new request is raised until the response arrives.
- R5: If no early stop applies, the walk issues four reads and fills with size code 0 (4 KB). The physical page number is bits [51:12] of the fourth entry.
- R6: If the third entry is present with bit 7 (page size) set, the walk ends after three reads. It fills with size code 1 (2 MB) and a page number equal to entry bits [51:12] with its low 9 bits cleared.
- R7: If the second entry is present with bit 7 set, the walk ends after two reads. It fills with size code 2 (1 GB) and a page number equal to entry bits [51:12] with its low 18 bits cleared.
- R8: Bit 7 of the first and fourth entries has no effect on the walk length or the size code.
- R9: An entry with bit 0 (present) clear ends the walk. It raises fault_valid for one cycle with fault_level equal to the read number (1 to 4) and the request tag. It issues no fill and no further read.
- R10: fill_valid is a one-cycle pulse. It carries fill_vpn = va[47:12] and the tag of the accepted miss.
- R11: Each fill increments by one the completion counter for its size. Each fault increments the fault counter by one.
- R12: The cycle counter increments once for every cycle in which busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Translation miss presented |
| miss_va | input | 48 | Virtual address of the miss |
| miss_tag | input | 12 | Requester tag returned with the result |
| root_base | input | 52 | Physical base of the top-level table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | 52 | Physical address of the entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| fill_valid | output | 1 | Translation fill pulse |
| fill_vpn | output | 36 | Virtual page number (va[47:12]) |
| fill_ppn | output | 40 | Physical page number in 4 KB units |
| fill_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| fill_tag | output | 12 | Tag of the filled miss |
| fault_valid | output | 1 | Walk fault pulse |
| fault_level | output | 3 | Read number (1 to 4) of the non-present entry |
| fault_tag | output | 12 | Tag of the faulting miss |
| cnt_4k | output | 32 | Completed 4 KB walks |
| cnt_2m | output | 32 | Completed 2 MB walks |
| cnt_1g | output | 32 | Completed 1 GB walks |
| cnt_fault | output | 32 | Faulted walks |
| cnt_cycles | output | 32 | Cycles with a walk in progress |

## Verification
The properties assume that memory returns exactly one response for each granted request, and never returns one while no read is outstanding. They also assume that mem_req_ready is only meaningful while a request is raised. The bench acts as that memory. It grants each request after a chosen delay, holds the response back for at least one cycle, and never raises mem_rsp_valid outside the waiting window. One scenario deliberately raises a miss during a walk, which is legal input that the walker must ignore.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_FILL,
        ST_FAULT
    } ptw_state_e;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } ptw_size_e;

    localparam int PTE_PRESENT_BIT = 0;
    localparam int PTE_LEAF_BIT    = 7;
    localparam int NUM_SIZES       = 3;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
    parameter int LEVELS  = 4,
    parameter int IDX_W   = 9,
    parameter int OFF_W   = 12,
    parameter int PA_W    = 52,
    localparam int VPN_W   = LEVELS * IDX_W,
    localparam int FRAME_W = PA_W - OFF_W,
    localparam int LVL_W   = $clog2(LEVELS),
    localparam int ESZ_W   = OFF_W - IDX_W
) (
    input  logic [VPN_W-1:0]   vpn,
    input  logic [LVL_W-1:0]   step,
    input  logic [FRAME_W-1:0] table_frame,
    output logic [PA_W-1:0]    entry_addr
);
    logic [IDX_W-1:0] idx_sel [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_sel[g] = vpn[IDX_W*(LEVELS-g)-1 -: IDX_W];
    end

    assign entry_addr = {table_frame, idx_sel[step], {ESZ_W{1'b0}}};
endmodule

// File: rtl/ptw_stats.sv
module ptw_stats #(
    parameter int CNT_W = 32,
    parameter int NSIZE = ptw_pkg::NUM_SIZES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fill_pulse,
    input  logic [1:0]                  fill_size,
    input  logic                        fault_pulse,
    input  logic                        active,
    output logic [NSIZE-1:0][CNT_W-1:0] size_cnt,
    output logic [CNT_W-1:0]            fault_cnt,
    output logic [CNT_W-1:0]            cycle_cnt
);
    for (genvar s = 0; s < NSIZE; s++) begin : g_size
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                size_cnt[s] <= '0;
            end else if (fill_pulse && (fill_size == 2'(s))) begin
                size_cnt[s] <= size_cnt[s] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_cnt <= '0;
            cycle_cnt <= '0;
        end else begin
            if (fault_pulse) fault_cnt <= fault_cnt + 1'b1;
            if (active)      cycle_cnt <= cycle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int VA_W   = 48,
    parameter int PA_W   = 52,
    parameter int DATA_W = 64,
    parameter int TAG_W  = 12,
    parameter int CNT_W  = 32,
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    localparam int VPN_W   = VA_W - OFF_W,
    localparam int FRAME_W = PA_W - OFF_W,
    localparam int LVL_W   = $clog2(LEVELS),
    localparam int FLVL_W  = LVL_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    input  logic [VA_W-1:0]    miss_va,
    input  logic [TAG_W-1:0]   miss_tag,
    input  logic [PA_W-1:0]    root_base,
    output logic               busy,
    output logic               mem_req_valid,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [DATA_W-1:0]  mem_rsp_data,
    output logic               fill_valid,
    output logic [VPN_W-1:0]   fill_vpn,
    output logic [FRAME_W-1:0] fill_ppn,
    output logic [1:0]         fill_size,
    output logic [TAG_W-1:0]   fill_tag,
    output logic               fault_valid,
    output logic [FLVL_W-1:0]  fault_level,
    output logic [TAG_W-1:0]   fault_tag,
    output logic [CNT_W-1:0]   cnt_4k,
    output logic [CNT_W-1:0]   cnt_2m,
    output logic [CNT_W-1:0]   cnt_1g,
    output logic [CNT_W-1:0]   cnt_fault,
    output logic [CNT_W-1:0]   cnt_cycles
);
    import ptw_pkg::*;

    localparam logic [FRAME_W-1:0] MASK_2M = {{(FRAME_W-IDX_W){1'b1}}, {IDX_W{1'b0}}};
    localparam logic [FRAME_W-1:0] MASK_1G = {{(FRAME_W-2*IDX_W){1'b1}}, {(2*IDX_W){1'b0}}};
    localparam logic [LVL_W-1:0]   STEP_1G = LVL_W'(LEVELS - 3);
    localparam logic [LVL_W-1:0]   STEP_2M = LVL_W'(LEVELS - 2);
    localparam logic [LVL_W-1:0]   STEP_LAST = LVL_W'(LEVELS - 1);

    ptw_state_e           state_q, state_d;
    logic [LVL_W-1:0]     step_q;
    logic [FRAME_W-1:0]   frame_q;
    logic [VPN_W-1:0]     vpn_q;
    logic [TAG_W-1:0]     tag_q;
    logic [FRAME_W-1:0]   ppn_q;
    ptw_size_e            size_q;
    logic [FLVL_W-1:0]    flvl_q;

    logic [FRAME_W-1:0]   rsp_frame;
    logic                 rsp_present;
    logic                 rsp_leaf_flag;
    logic                 rsp_is_leaf;
    ptw_size_e            leaf_size;
    logic [FRAME_W-1:0]   leaf_frame;
    logic [NUM_SIZES-1:0][CNT_W-1:0] size_cnt;
    logic                 rsp_unused_bits;

    assign rsp_frame     = mem_rsp_data[PA_W-1:OFF_W];
    assign rsp_present   = mem_rsp_data[PTE_PRESENT_BIT];
    assign rsp_leaf_flag = mem_rsp_data[PTE_LEAF_BIT];
    assign rsp_unused_bits = ^{mem_rsp_data[DATA_W-1:PA_W], mem_rsp_data[OFF_W-1:PTE_LEAF_BIT+1],
                               mem_rsp_data[PTE_LEAF_BIT-1:PTE_PRESENT_BIT+1], miss_va[OFF_W-1:0],
                               root_base[OFF_W-1:0]};

    // Leaf decision: size flag honoured only at the 1 GB and 2 MB steps
    always_comb begin
        rsp_is_leaf = (step_q == STEP_LAST) ||
                      (rsp_leaf_flag && ((step_q == STEP_1G) || (step_q == STEP_2M)));
        if (step_q == STEP_1G) begin
            leaf_size  = PG_1G;
            leaf_frame = rsp_frame & MASK_1G;
        end else if (step_q == STEP_2M) begin
            leaf_size  = PG_2M;
            leaf_frame = rsp_frame & MASK_2M;
        end else begin
            leaf_size  = PG_4K;
            leaf_frame = rsp_frame;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_valid)    state_d = ST_REQ;
            ST_REQ:   if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!rsp_present)     state_d = ST_FAULT;
                    else if (rsp_is_leaf) state_d = ST_FILL;
                    else                  state_d = ST_REQ;
                end
            end
            ST_FILL:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= '0;
            frame_q <= '0;
            vpn_q   <= '0;
            tag_q   <= '0;
            ppn_q   <= '0;
            size_q  <= PG_4K;
            flvl_q  <= '0;
        end else if (state_q == ST_IDLE && miss_valid) begin
            step_q  <= '0;
            frame_q <= root_base[PA_W-1:OFF_W];
            vpn_q   <= miss_va[VA_W-1:OFF_W];
            tag_q   <= miss_tag;
        end else if (state_q == ST_WAIT && mem_rsp_valid) begin
            if (!rsp_present) begin
                flvl_q <= FLVL_W'(step_q) + 1'b1;
            end else if (rsp_is_leaf) begin
                ppn_q  <= leaf_frame;
                size_q <= leaf_size;
            end else begin
                frame_q <= rsp_frame;
                step_q  <= step_q + 1'b1;
            end
        end
    end

    ptw_index #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)
    ) u_index (
        .vpn         (vpn_q),
        .step        (step_q),
        .table_frame (frame_q),
        .entry_addr  (mem_req_addr)
    );

    // Outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        mem_req_valid = (state_q == ST_REQ);
        fill_valid    = (state_q == ST_FILL);
        fault_valid   = (state_q == ST_FAULT);
        fill_vpn      = vpn_q;
        fill_ppn      = ppn_q;
        fill_size     = size_q;
        fill_tag      = tag_q;
        fault_tag     = tag_q;
        fault_level   = flvl_q;
    end

    ptw_stats #(.CNT_W(CNT_W), .NSIZE(NUM_SIZES)) u_stats (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_pulse  (fill_valid),
        .fill_size   (fill_size),
        .fault_pulse (fault_valid),
        .active      (busy),
        .size_cnt    (size_cnt),
        .fault_cnt   (cnt_fault),
        .cycle_cnt   (cnt_cycles)
    );

    assign cnt_4k = size_cnt[PG_4K];
    assign cnt_2m = size_cnt[PG_2M];
    assign cnt_1g = size_cnt[PG_1G];
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_W   = 52,
    parameter int CNT_W  = 32,
    parameter int FLVL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [PA_W-1:0]   mem_req_addr,
    input logic              fill_valid,
    input logic [1:0]        fill_size,
    input logic              fault_valid,
    input logic [FLVL_W-1:0] fault_level,
    input logic [CNT_W-1:0]  cnt_4k,
    input logic [CNT_W-1:0]  cnt_fault,
    input logic [CNT_W-1:0]  cnt_cycles
);
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && miss_valid) |=> busy); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !fill_valid && !fault_valid)); // R2
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R4
    AST_SIZE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (fill_size != 2'd3)); // R5
    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid)); // R9
    AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> ((fault_level >= 1) && (fault_level <= 4))); // R9
    AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (!fill_valid && !busy)); // R10
    AST_CNT_4K: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_size == 2'd0) |=> (cnt_4k == $past(cnt_4k) + 1'b1)); // R11
    AST_CNT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> (cnt_fault == $past(cnt_fault) + 1'b1)); // R11
    AST_CNT_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt_cycles == $past(cnt_cycles) + 1'b1)); // R12
endmodule

bind ptw_walker ptw_walker_chk #(
    .PA_W(PA_W), .CNT_W(CNT_W), .FLVL_W(FLVL_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .fill_valid    (fill_valid),
    .fill_size     (fill_size),
    .fault_valid   (fault_valid),
    .fault_level   (fault_level),
    .cnt_4k        (cnt_4k),
    .cnt_fault     (cnt_fault),
    .cnt_cycles    (cnt_cycles)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic [47:0]  miss_va = '0;
    logic [11:0]  miss_tag = '0;
    logic [51:0]  root_base = 52'h0_0000_0010_0000;
    logic         busy;
    logic         mem_req_valid;
    logic [51:0]  mem_req_addr;
    logic         mem_req_ready = 1'b0;
    logic         mem_rsp_valid = 1'b0;
    logic [63:0]  mem_rsp_data = '0;
    logic         fill_valid;
    logic [35:0]  fill_vpn;
    logic [39:0]  fill_ppn;
    logic [1:0]   fill_size;
    logic [11:0]  fill_tag;
    logic         fault_valid;
    logic [2:0]   fault_level;
    logic [11:0]  fault_tag;
    logic [31:0]  cnt_4k, cnt_2m, cnt_1g, cnt_fault, cnt_cycles;

    int checks = 0;
    int errors = 0;
    int busy_mon = 0;
    int exp_4k = 0, exp_2m = 0, exp_1g = 0, exp_fault = 0;

    always #10 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_va(miss_va),
        .miss_tag(miss_tag), .root_base(root_base), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_size(fill_size), .fill_tag(fill_tag),
        .fault_valid(fault_valid), .fault_level(fault_level), .fault_tag(fault_tag),
        .cnt_4k(cnt_4k), .cnt_2m(cnt_2m), .cnt_1g(cnt_1g), .cnt_fault(cnt_fault),
        .cnt_cycles(cnt_cycles)
    );

    always @(negedge clk) if (rst_n && busy) busy_mon++;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] pte(input logic [39:0] frame, input bit leaf, input bit present);
        return {12'h000, frame, 4'h0, leaf, 6'b000000, present};
    endfunction

    task automatic check_counters();
        chk("R11", "4 KB count", cnt_4k, exp_4k);
        chk("R11", "2 MB count", cnt_2m, exp_2m);
        chk("R11", "1 GB count", cnt_1g, exp_1g);
        chk("R11", "fault count", cnt_fault, exp_fault);
        chk("R12", "walk cycles", cnt_cycles, busy_mon);
    endtask

    // One walk: bench acts as memory, returning ents[k] for read k
    task automatic do_walk(input string rq, input logic [47:0] va, input logic [11:0] tag,
                           input logic [63:0] e0, input logic [63:0] e1,
                           input logic [63:0] e2, input logic [63:0] e3,
                           input int nreads, input bit faulting, input logic [1:0] sz,
                           input int lat, input bit poke);
        logic [63:0] ents [4];
        logic [39:0] frame;
        logic [8:0]  idx;
        logic [51:0] exp_addr;
        logic [39:0] exp_ppn;
        ents[0] = e0; ents[1] = e1; ents[2] = e2; ents[3] = e3;
        frame = root_base[51:12];
        @(negedge clk);
        miss_valid = 1'b1; miss_va = va; miss_tag = tag;
        @(negedge clk);
        miss_valid = 1'b0; miss_va = '0; miss_tag = '0;
        chk("R2", "busy after accept", busy, 1);
        for (int k = 0; k < nreads; k++) begin
            idx = 9'((va >> (39 - 9 * k)) & 48'h1FF);
            exp_addr = {frame, idx, 3'b000};
            for (int t = 0; t < 50 && !mem_req_valid; t++) @(negedge clk);
            chk("R3", $sformatf("read %0d address", k + 1), {mem_req_valid, mem_req_addr}, {1'b1, exp_addr});
            for (int w = 0; w < lat; w++) begin
                @(negedge clk);
                chk("R4", "request held", {mem_req_valid, mem_req_addr}, {1'b1, exp_addr});
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            if (poke && k == 0) begin
                miss_valid = 1'b1; miss_va = 48'hFFFF_FFFF_F000; miss_tag = 12'hFFF;
            end
            for (int w = 0; w <= lat; w++) begin
                @(negedge clk);
                miss_valid = 1'b0; miss_va = '0; miss_tag = '0;
                chk("R4", "no request while waiting", mem_req_valid, 0);
            end
            mem_rsp_valid = 1'b1; mem_rsp_data = ents[k];
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_data = '0;
            frame = ents[k][51:12];
        end
        if (faulting) begin
            chk("R9", "fault pulse", {fault_valid, fill_valid, mem_req_valid}, 3'b100);
            chk("R9", "fault level", fault_level, nreads);
            chk("R9", "fault tag", fault_tag, tag);
            exp_fault++;
        end else begin
            exp_ppn = frame;
            if (sz == 2'd1) exp_ppn = frame & ~40'h1FF;
            if (sz == 2'd2) exp_ppn = frame & ~40'h3FFFF;
            chk(rq, "fill pulse", {fill_valid, fault_valid}, 2'b10);
            chk(rq, "fill size", fill_size, sz);
            chk(rq, "fill ppn", fill_ppn, exp_ppn);
            chk("R10", "fill vpn", fill_vpn, va[47:12]);
            chk("R10", "fill tag", fill_tag, tag);
            if (sz == 2'd0) exp_4k++;
            if (sz == 2'd1) exp_2m++;
            if (sz == 2'd2) exp_1g++;
        end
        @(negedge clk);
        chk("R2", "idle after outcome", {busy, mem_req_valid, fill_valid, fault_valid}, 0);
        check_counters();
        repeat (2) @(negedge clk);
        chk("R2", "no walk started afterwards", {busy, mem_req_valid}, 0);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "idle outputs", {busy, mem_req_valid, fill_valid, fault_valid}, 0);
        chk("R1", "counters", {cnt_4k, cnt_2m, cnt_1g, cnt_fault, cnt_cycles} == '0, 1);
    endtask

    task automatic test_4k();
        do_walk("R5", 48'h1234_5678_9ABC, 12'h011,
                pte(40'h00_0000_0200, 0, 1), pte(40'h00_0000_0300, 0, 1),
                pte(40'h00_0000_0400, 0, 1), pte(40'h00_0ABC_D123, 0, 1),
                4, 0, 2'd0, 0, 0);
    endtask

    task automatic test_flag_ignored();
        do_walk("R8", 48'h7FFF_8001_2345, 12'h022,
                pte(40'h00_0000_0500, 1, 1), pte(40'h00_0000_0600, 0, 1),
                pte(40'h00_0000_0700, 0, 1), pte(40'h00_0012_3457, 1, 1),
                4, 0, 2'd0, 3, 1);
    endtask

    task automatic test_2m();
        do_walk("R6", 48'h0ABC_DEF1_2000, 12'h033,
                pte(40'h00_0000_0800, 0, 1), pte(40'h00_0000_0900, 0, 1),
                pte(40'h00_1234_5ABC, 1, 1), pte(40'h00_FFFF_FFFF, 0, 1),
                3, 0, 2'd1, 1, 0);
    endtask

    task automatic test_1g();
        do_walk("R7", 48'h5555_AAAA_5000, 12'h044,
                pte(40'h00_0000_0A00, 0, 1), pte(40'h00_ABCD_E123, 1, 1),
                pte(40'h00_FFFF_FFFF, 1, 1), pte(40'h00_FFFF_FFFF, 1, 1),
                2, 0, 2'd2, 2, 0);
    endtask

    task automatic test_faults();
        do_walk("R9", 48'h0000_0040_1000, 12'h055,
                pte(40'h00_0000_0B00, 0, 0), '0, '0, '0, 1, 1, 2'd0, 0, 0);
        do_walk("R9", 48'h0001_0203_4000, 12'h066,
                pte(40'h00_0000_0C00, 0, 1), pte(40'h00_0000_0D00, 0, 1),
                pte(40'h00_0000_0E00, 1, 0), '0, 3, 1, 2'd0, 1, 0);
        do_walk("R9", 48'h0F0F_0F0F_0000, 12'h077,
                pte(40'h00_0000_0F00, 0, 1), pte(40'h00_0000_1000, 0, 1),
                pte(40'h00_0000_1100, 0, 1), pte(40'h00_0000_1200, 0, 0),
                4, 1, 2'd0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_4k();
        test_flag_ignored();
        test_2m();
        test_1g();
        test_faults();
        test_4k();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule